// File: doc/BRIEF.md
# DRAM Mode Register Command Sequencer

This block sits on the controller side of a DDR3-style memory interface. It issues mode register set commands and enforces the delays that follow them. It keeps a shadow image of the four mode registers. A request carries a register index, a bit mask and new bit values. The block merges the masked bits into the shadow image and always drives the complete merged word on the address bus, so a partial update never leaves other fields undefined.

A request is taken through a valid/ready handshake, one at a time. Ready is high only when the memory reports all banks idle and precharged, no data burst is running, no power-down entry is requested, and every delay counter has expired. Once a request is accepted, the command pulse, bank select and address appear on the next cycle. The block then drives three outputs for the rest of the controller, all derived from down-counters started by that command:

- a flag that blocks other commands during the mode-update window;
- a flag that blocks commands needing the DLL after a DLL reset;
- a clock-enable output that stays high until power-down entry is safe.

The DLL-reset bit of register 0 clears itself in the shadow image after it is issued. Reset restores the shadow image to parameter defaults.

Top module: `mrs_sequencer`

## Requirements
- R1: `req_ready` is high exactly when `banks_idle` is 1, `burst_active` is 0, `pd_req` is 0 and no delay counter is running; the command is issued only after a request is accepted.
- R2: The cycle after `req_valid && req_ready`, `mem_mrs` is 1 for one cycle and `mem_ba` is `{1'b0, req_idx}`. `mem_addr` is `(shadow & ~req_mask) | (req_data & req_mask)`, the shadow being the stored image of the selected register. When no command is issued, `mem_mrs`, `mem_ba` and `mem_addr` are 0.
- R3: Two `mem_mrs` pulses are separated by at least `T_MRD` cycles.
- R4: `cmd_allowed` is 0 in the cycle of a `mem_mrs` pulse and for the next `T_MOD-1` cycles, and returns to 1 `T_MOD` cycles after the pulse.
- R5: When register 0 is written with bit 8 (DLL reset) set, the shadow image of register 0 stores bit 8 as 0. A later register-0 write with mask 0 shows bit 8 low.
- R6: After a register-0 command with bit 8 set, `dll_ok` is 0 from the pulse cycle until `T_DLLK` cycles after it.
- R7: `mem_cke` is 0 only when `pd_req` is 1 and the mode-update counter has expired; during the `T_MOD` window it stays 1 whatever `pd_req` does.
- R8: While `rst_n` is low, the shadow images return to `MR0_INIT` to `MR3_INIT` and all counters clear.
- R9: `mrs_busy` is 1 in the pulse cycle and while any delay counter is non-zero; while it is 1, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, also the memory reset |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_idx | input | 2 | Target mode register 0..3 |
| req_mask | input | ADDR_W | Bits to replace |
| req_data | input | ADDR_W | New values for the masked bits |
| banks_idle | input | 1 | All banks idle, precharged, precharge delay met |
| burst_active | input | 1 | A data burst is in progress |
| pd_req | input | 1 | Controller wants to enter power-down |
| mem_mrs | output | 1 | Mode register set command pulse |
| mem_ba | output | 3 | Bank select carrying the register index |
| mem_addr | output | ADDR_W | Full register image |
| mem_cke | output | 1 | Clock enable to the memory |
| cmd_allowed | output | 1 | Commands other than MRS/NOP/deselect permitted |
| dll_ok | output | 1 | DLL-dependent commands permitted |
| mrs_busy | output | 1 | A command or delay window is active |

## Verification
The assertions check the following on every cycle:
- the issue conditions at each handshake;
- the bank select that follows acceptance;
- the minimum spacing between pulses;
- the `cmd_allowed` drop at each pulse;
- clock enable held high through the pulse and the update window;
- ready low while busy.

The exact length of each window, the merged address value, the self-clearing DLL bit and the restored defaults after reset need knowledge of earlier writes. Only the bench's reference model shows these, by tracking the shadow image through directed and random request streams.

// File: rtl/mrs_sequencer.sv
module mrs_sequencer #(
  parameter int ADDR_W = 14,
  parameter int T_MRD  = 4,
  parameter int T_MOD  = 12,
  parameter int T_DLLK = 512,
  parameter logic [ADDR_W-1:0] MR0_INIT = 'h0420,
  parameter logic [ADDR_W-1:0] MR1_INIT = 'h0044,
  parameter logic [ADDR_W-1:0] MR2_INIT = 'h0008,
  parameter logic [ADDR_W-1:0] MR3_INIT = 'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_idx,
  input  logic [ADDR_W-1:0] req_mask,
  input  logic [ADDR_W-1:0] req_data,
  input  logic              banks_idle,
  input  logic              burst_active,
  input  logic              pd_req,
  output logic              mem_mrs,
  output logic [2:0]        mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cke,
  output logic              cmd_allowed,
  output logic              dll_ok,
  output logic              mrs_busy
);
  localparam int DLL_BIT = 8;
  localparam int TMAX = (T_DLLK > T_MOD) ? ((T_DLLK > T_MRD) ? T_DLLK : T_MRD)
                                         : ((T_MOD > T_MRD) ? T_MOD : T_MRD);
  localparam int CW = $clog2(TMAX + 1);

  logic [ADDR_W-1:0] shadow [4];
  logic [CW-1:0] mrd_cnt, mod_cnt, dll_cnt;
  logic [ADDR_W-1:0] merged, stored;
  logic accept, counting;

  function automatic logic [ADDR_W-1:0] init_val(input int i);
    case (i)
      0: init_val = MR0_INIT;
      1: init_val = MR1_INIT;
      2: init_val = MR2_INIT;
      default: init_val = MR3_INIT;
    endcase
  endfunction

  assign counting    = (mrd_cnt != '0) || (mod_cnt != '0) || (dll_cnt != '0);
  assign req_ready   = banks_idle && !burst_active && !pd_req && !counting;
  assign accept      = req_valid && req_ready;
  assign merged      = (shadow[req_idx] & ~req_mask) | (req_data & req_mask);
  assign cmd_allowed = (mod_cnt == '0);
  assign dll_ok      = (dll_cnt == '0);
  assign mrs_busy    = mem_mrs || counting;
  assign mem_cke     = !(pd_req && mod_cnt == '0);

  always_comb begin
    stored = merged;
    if (req_idx == 2'd0) stored[DLL_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) shadow[i] <= init_val(i);
      mem_mrs  <= 1'b0;
      mem_ba   <= '0;
      mem_addr <= '0;
      mrd_cnt  <= '0;
      mod_cnt  <= '0;
      dll_cnt  <= '0;
    end else begin
      mem_mrs  <= accept;
      mem_ba   <= accept ? {1'b0, req_idx} : 3'd0;
      mem_addr <= accept ? merged : '0;
      if (accept) begin
        shadow[req_idx] <= stored;
        mrd_cnt <= CW'(T_MRD);
        mod_cnt <= CW'(T_MOD);
        if (req_idx == 2'd0 && merged[DLL_BIT]) dll_cnt <= CW'(T_DLLK);
      end else begin
        if (mrd_cnt != '0) mrd_cnt <= mrd_cnt - 1'b1;
        if (mod_cnt != '0) mod_cnt <= mod_cnt - 1'b1;
        if (dll_cnt != '0) dll_cnt <= dll_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mrs_sequencer_chk.sv
module mrs_sequencer_chk #(
  parameter int T_MRD = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_idx,
  input logic       banks_idle,
  input logic       burst_active,
  input logic       pd_req,
  input logic       mem_mrs,
  input logic [2:0] mem_ba,
  input logic       mem_cke,
  input logic       cmd_allowed,
  input logic       mrs_busy
);
  logic [15:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 16'hFFFF;
    else if (mem_mrs) gap <= 16'd1;
    else if (gap != 16'hFFFF) gap <= gap + 16'd1;
  end

  // R1
  issue_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (banks_idle && !burst_active && !pd_req));
  // R2
  bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_mrs && mem_ba == {1'b0, $past(req_idx)}));
  // R3
  mrs_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_mrs |-> (gap >= 16'(T_MRD)));
  // R4
  allowed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_mrs |-> !cmd_allowed);
  // R7
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_mrs || !cmd_allowed) |-> mem_cke);
  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_busy |-> !req_ready);
endmodule

bind mrs_sequencer mrs_sequencer_chk #(.T_MRD(T_MRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_idx(req_idx), .banks_idle(banks_idle), .burst_active(burst_active),
  .pd_req(pd_req), .mem_mrs(mem_mrs), .mem_ba(mem_ba), .mem_cke(mem_cke),
  .cmd_allowed(cmd_allowed), .mrs_busy(mrs_busy));

// File: tb/mrs_sequencer_tb.sv
`timescale 1ns/1ps
module mrs_sequencer_tb;
  localparam int AW = 14, TMRD = 4, TMOD = 12, TDLLK = 512;
  localparam logic [AW-1:0] I0 = 'h0420, I1 = 'h0044, I2 = 'h0008, I3 = 'h0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, banks_idle = 1, burst_active = 0, pd_req = 0;
  logic [1:0] req_idx = 0;
  logic [AW-1:0] req_mask = 0, req_data = 0;
  logic req_ready, mem_mrs, mem_cke, cmd_allowed, dll_ok, mrs_busy;
  logic [2:0] mem_ba;
  logic [AW-1:0] mem_addr;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [AW-1:0] sh [4];
  int mrd_l = 0, mod_l = 0, dll_l = 0;
  bit e_mrs = 0, m_acc = 0;
  logic [2:0] e_ba = 0;
  logic [AW-1:0] e_addr = 0;
  int last_mrs = -100, min_gap = 1000;

  always #5 clk = ~clk;

  mrs_sequencer #(.ADDR_W(AW), .T_MRD(TMRD), .T_MOD(TMOD), .T_DLLK(TDLLK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_mask(req_mask), .req_data(req_data),
    .banks_idle(banks_idle), .burst_active(burst_active), .pd_req(pd_req),
    .mem_mrs(mem_mrs), .mem_ba(mem_ba), .mem_addr(mem_addr), .mem_cke(mem_cke),
    .cmd_allowed(cmd_allowed), .dll_ok(dll_ok), .mrs_busy(mrs_busy));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit m_ready();
    return banks_idle && !burst_active && !pd_req && mrd_l == 0 && mod_l == 0 && dll_l == 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      sh[0] = I0; sh[1] = I1; sh[2] = I2; sh[3] = I3;
      mrd_l = 0; mod_l = 0; dll_l = 0; e_mrs = 0; e_ba = 0; e_addr = 0; m_acc = 0;
    end else begin
      logic [AW-1:0] mg;
      m_acc = req_valid && m_ready();
      mg = (sh[req_idx] & ~req_mask) | (req_data & req_mask);
      if (mrd_l > 0) mrd_l--;
      if (mod_l > 0) mod_l--;
      if (dll_l > 0) dll_l--;
      e_mrs = m_acc;
      e_ba = m_acc ? {1'b0, req_idx} : 3'd0;
      e_addr = m_acc ? mg : '0;
      if (m_acc) begin
        sh[req_idx] = mg;
        if (req_idx == 0) sh[0][8] = 1'b0;
        mrd_l = TMRD; mod_l = TMOD;
        if (req_idx == 0 && mg[8]) dll_l = TDLLK;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 ready", req_ready, m_ready());
      check("R2 pulse", mem_mrs, e_mrs);
      check("R2 bank", mem_ba, e_ba);
      check("R2 addr", mem_addr, e_addr);
      check("R4 allowed", cmd_allowed, mod_l == 0);
      check("R6 dll_ok", dll_ok, dll_l == 0);
      check("R7 cke", mem_cke, !(pd_req && mod_l == 0));
      check("R9 busy", mrs_busy, e_mrs || mrd_l != 0 || mod_l != 0 || dll_l != 0);
      if (mem_mrs) begin
        if (cyc - last_mrs < min_gap) min_gap = cyc - last_mrs;
        last_mrs = cyc;
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic send(logic [1:0] idx, logic [AW-1:0] msk, logic [AW-1:0] dat);
    req_valid = 1; req_idx = idx; req_mask = msk; req_data = dat;
    do step(); while (!m_acc);
    req_valid = 0;
  endtask

  task automatic drain();
    while (mrs_busy || !req_ready) step();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    @(negedge clk); rst_n = 1;
    step();
    // R8 reset state
    check("R8 ready after reset", req_ready, 1);
    check("R8 addr after reset", mem_addr, 0);
    // R2 full image from shadow with empty mask
    send(2'd1, '0, '0);
    @(negedge clk); check("R2 MR1 default image", mem_addr, I1);
    drain();
    // R2 partial merge
    send(2'd2, 'h0038, 'h0010);
    @(negedge clk); check("R2 merged MR2", mem_addr, (I2 & ~14'h0038) | 14'h0010);
    drain();
    // R1 stall on banks not idle and burst
    banks_idle = 0; req_valid = 1; req_idx = 3; req_mask = '1; req_data = 'h0004;
    step(10);
    check("R1 stalled banks", m_acc, 0);
    banks_idle = 1; burst_active = 1; step(10);
    check("R1 stalled burst", m_acc, 0);
    burst_active = 0;
    do step(); while (!m_acc);
    req_valid = 0;
    drain();
    // R3 back-to-back requests
    last_mrs = -100; min_gap = 1000;
    send(2'd1, 'h0001, 'h0001);
    send(2'd1, 'h0001, 'h0000);
    step(2);
    check("R3 min spacing", min_gap >= TMRD, 1);
    drain();
    // R6 / R5 DLL reset
    send(2'd0, 'h0100, 'h0100);
    @(negedge clk); check("R6 dll low after reset cmd", dll_ok, 0);
    drain();
    send(2'd0, '0, '0);
    @(negedge clk); check("R5 bit8 cleared", mem_addr[8], 0);
    drain();
    // R7 power-down request during update window
    send(2'd3, 'h0003, 'h0002);
    pd_req = 1; step(3);
    @(negedge clk); check("R7 cke held", mem_cke, 1);
    step(TMOD + 2);
    @(negedge clk); check("R7 cke released", mem_cke, 0);
    pd_req = 0; drain();
    // R8 mid-run reset restores defaults
    send(2'd2, '1, 'h3FFF);
    drain();
    @(negedge clk); rst_n = 0; step(2);
    @(negedge clk); rst_n = 1; step();
    send(2'd2, '0, '0);
    @(negedge clk); check("R8 MR2 restored", mem_addr, I2);
    drain();
    // random stream
    for (int i = 0; i < 4000; i++) begin
      req_valid    = ($urandom % 3) == 0;
      req_idx      = 2'($urandom);
      req_mask     = AW'($urandom);
      req_data     = AW'($urandom);
      banks_idle   = ($urandom % 8) != 0;
      burst_active = ($urandom % 10) == 0;
      pd_req       = ($urandom % 10) == 0;
      step();
    end
    req_valid = 0;
    step(2);
    finish_run();
  end
endmodule